// File: doc/BRIEF.md
# Processor Suspend Handshake Sequencer

This block moves the processor, and optionally the whole system, into a low-power state when software writes one of two command registers. A write pulse starts a request/acknowledge exchange with the processor: the block pulls its active-low suspend request down and waits for the processor's active-low acknowledge. What follows depends on which command was written and on a mode bit. The result is either a plain processor halt or a full stop with the system clocks gated by a clock-stop output.

Leaving the low-power state is driven by wake events, which are unmasked interrupt or system-management requests. After a halt, the request is released straight away. After a full stop, the clock-stop output drops first. The block then counts a settling period in units of an external timebase tick before it releases the request. That period comes from a 4-bit field for the halt command in full mode, and is a short fixed count for the stop-clock command. The sequence ends when the processor withdraws its acknowledge.

Top module: `suspSeqTop`

## Requirements
- R1: While idle, a write pulse on either command input makes `suspReqN` low and `busy` high one cycle later; the value on `cmdData` has no effect on the sequence.
- R2: `suspReqN` stays low and `clkStopOut` stays low for as long as `suspAckN` stays high after a command is accepted.
- R3: For a halt command accepted with `fullSuspMode` = 0, `clkStopOut` never rises; a pulse on `wakeIrq` or `wakeSmi` after the acknowledge raises `suspReqN` one cycle later.
- R4: For a halt command accepted with `fullSuspMode` = 1, `clkStopOut` goes high one cycle after `suspAckN` goes low. The mode bit is sampled on the command write.
- R5: In full-suspend mode a wake pulse drops `clkStopOut` one cycle later, and `suspReqN` rises one cycle after the Nth `tick` pulse, where N is `pllDelayCode` (value 0 counts as 1).
- R6: A stop-clock command raises `clkStopOut` after the acknowledge whatever the mode bit is. On wake it drops `clkStopOut`, and `suspReqN` rises one cycle after the `SHORT_TICKS`th tick (default 2).
- R7: After `suspReqN` is released, `busy` stays high until `suspAckN` is high, and it goes low the cycle after that.
- R8: Command write pulses are ignored while `busy` is high, including in the release phase.
- R9: A wake pulse seen before the acknowledge is remembered. On the acknowledge, a halt releases `suspReqN` at once, and a full or stop-clock sequence goes straight to its settling count without raising `clkStopOut`.
- R10: Wake pulses while idle have no effect. When both command strobes arrive in the same cycle, the stop-clock command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| haltCmdWr | input | 1 | Write pulse for the processor-suspend command register |
| stopClkCmdWr | input | 1 | Write pulse for the stop-clock command register |
| cmdData | input | 8 | Data on the command write; not used |
| fullSuspMode | input | 1 | 1 selects full suspend for the halt command |
| pllDelayCode | input | 4 | Settling delay in ticks for full-suspend resume |
| suspAckN | input | 1 | Processor suspend acknowledge, active low |
| wakeIrq | input | 1 | Unmasked interrupt wake event |
| wakeSmi | input | 1 | Unmasked system-management wake event |
| tick | input | 1 | One-cycle timebase pulse for the settling count |
| suspReqN | output | 1 | Suspend request to the processor, active low |
| clkStopOut | output | 1 | Clock-stop request to the clock source |
| busy | output | 1 | Sequence in progress |

## Verification
The bench tests the settling count at its edges: code 0, code 15, a mid value, and the fixed short count. An off-by-one counter would show up there as a request released one tick early or one tick late. It sends wake pulses before the acknowledge. A design that lost them would hang in the low-power state, and one that ignored the handshake would release before the acknowledge. It also writes commands in the busy phases, including the release phase with the acknowledge still low; a design that restarted there would show a second drop of the request. Finally, it issues both strobes at once and compares two data values to prove that command choice and data handling are correct.

// File: rtl/suspSeqPkg.sv
package suspSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_HALT,
    ST_STOPPED,
    ST_DELAY,
    ST_RELEASE
  } seqState_e;

  typedef enum logic [1:0] {
    KIND_HALT,
    KIND_FULL,
    KIND_STOPCLK
  } seqKind_e;

  typedef struct packed {
    logic loadPll;
    logic loadShort;
    logic setWake;
    logic clrWake;
  } seqStrobe_t;

endpackage

// File: rtl/suspSeqData.sv
module suspSeqData
  import suspSeqPkg::*;
#(
  parameter int PLL_W       = 4,
  parameter int SHORT_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [PLL_W-1:0] pllDelayCode,
  input  logic             tick,
  input  logic             wakeAny,
  output logic             delayDone,
  output logic             wakePending
);

  localparam int SHORT_W = $clog2(SHORT_TICKS + 1);
  localparam int CNT_W   = (SHORT_W > PLL_W) ? SHORT_W : PLL_W;

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] pllLoad;

  // code 0 still waits one full tick
  always_comb begin
    pllLoad = CNT_W'(pllDelayCode);
    if (pllDelayCode == '0) pllLoad = CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.loadPll) begin
      tickCnt <= pllLoad;
    end else if (strb.loadShort) begin
      tickCnt <= CNT_W'(SHORT_TICKS);
    end else if (tick && tickCnt != '0) begin
      tickCnt <= tickCnt - CNT_W'(1);
    end
  end

  assign delayDone = tick && (tickCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakePending <= 1'b0;
    end else if (strb.clrWake) begin
      wakePending <= 1'b0;
    end else if (strb.setWake && wakeAny) begin
      wakePending <= 1'b1;
    end
  end

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadPll || strb.loadShort) |=> (tickCnt != '0)); // R5

  AST_WAKE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setWake && wakeAny && !strb.clrWake) |=> wakePending); // R9

endmodule

// File: rtl/suspSeqCtrl.sv
module suspSeqCtrl
  import suspSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltCmdWr,
  input  logic       stopClkCmdWr,
  input  logic       fullSuspMode,
  input  logic       suspAckN,
  input  logic       wakeAny,
  input  logic       delayDone,
  input  logic       wakePending,
  output seqStrobe_t strb,
  output logic       suspReqN,
  output logic       clkStopOut,
  output logic       busy
);

  seqState_e state, stateNext;
  seqKind_e  kind, kindNext;
  logic      wakeSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= KIND_HALT;
    end else begin
      state <= stateNext;
      kind  <= kindNext;
    end
  end

  assign wakeSeen = wakePending || wakeAny;

  always_comb begin
    stateNext = state;
    kindNext  = kind;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (stopClkCmdWr) begin
          stateNext = ST_REQ;
          kindNext  = KIND_STOPCLK;
        end else if (haltCmdWr) begin
          stateNext = ST_REQ;
          kindNext  = fullSuspMode ? KIND_FULL : KIND_HALT;
        end
      end
      ST_REQ: begin
        strb.setWake = 1'b1;
        if (!suspAckN) begin
          if (kind == KIND_HALT) begin
            stateNext = wakeSeen ? ST_RELEASE : ST_HALT;
          end else if (wakeSeen) begin
            stateNext      = ST_DELAY;
            strb.loadPll   = (kind == KIND_FULL);
            strb.loadShort = (kind == KIND_STOPCLK);
          end else begin
            stateNext = ST_STOPPED;
          end
        end
      end
      ST_HALT: begin
        if (wakeAny) stateNext = ST_RELEASE;
      end
      ST_STOPPED: begin
        if (wakeAny) begin
          stateNext      = ST_DELAY;
          strb.loadPll   = (kind == KIND_FULL);
          strb.loadShort = (kind == KIND_STOPCLK);
        end
      end
      ST_DELAY: begin
        if (delayDone) stateNext = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (suspAckN) begin
          stateNext    = ST_IDLE;
          strb.clrWake = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign suspReqN   = (state == ST_IDLE) || (state == ST_RELEASE);
  assign clkStopOut = (state == ST_STOPPED);
  assign busy       = (state != ST_IDLE);

  AST_START_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (haltCmdWr || stopClkCmdWr)) |=> (busy && !suspReqN)); // R1

  AST_STOP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStopOut) |-> $past(!suspAckN)); // R2

  AST_STOP_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    clkStopOut |-> !suspReqN); // R6

  AST_HALT_NO_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && kind == KIND_HALT) |-> !clkStopOut); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (suspReqN && !clkStopOut)); // R7

  AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DELAY && !delayDone) |=> !suspReqN); // R5

  AST_BUSY_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (busy && suspReqN && !suspAckN) |=> busy); // R7

endmodule

// File: rtl/suspSeqTop.sv
module suspSeqTop
  import suspSeqPkg::*;
#(
  parameter int PLL_W       = 4,
  parameter int DATA_W      = 8,
  parameter int SHORT_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltCmdWr,
  input  logic              stopClkCmdWr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              fullSuspMode,
  input  logic [PLL_W-1:0]  pllDelayCode,
  input  logic              suspAckN,
  input  logic              wakeIrq,
  input  logic              wakeSmi,
  input  logic              tick,
  output logic              suspReqN,
  output logic              clkStopOut,
  output logic              busy
);

  seqStrobe_t strb;
  logic       wakeAny;
  logic       delayDone;
  logic       wakePending;
  logic       dataUnused;

  assign wakeAny    = wakeIrq || wakeSmi;
  assign dataUnused = ^cmdData;

  suspSeqCtrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .haltCmdWr    (haltCmdWr),
    .stopClkCmdWr (stopClkCmdWr),
    .fullSuspMode (fullSuspMode),
    .suspAckN     (suspAckN),
    .wakeAny      (wakeAny),
    .delayDone    (delayDone),
    .wakePending  (wakePending),
    .strb         (strb),
    .suspReqN     (suspReqN),
    .clkStopOut   (clkStopOut),
    .busy         (busy)
  );

  suspSeqData #(
    .PLL_W       (PLL_W),
    .SHORT_TICKS (SHORT_TICKS)
  ) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .pllDelayCode (pllDelayCode),
    .tick         (tick),
    .wakeAny      (wakeAny),
    .delayDone    (delayDone),
    .wakePending  (wakePending)
  );

endmodule

// File: tb/suspSeqTop_tb_top.sv
module suspSeqTop_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       haltCmdWr = 1'b0;
  logic       stopClkCmdWr = 1'b0;
  logic [7:0] cmdData = 8'h00;
  logic       fullSuspMode = 1'b0;
  logic [3:0] pllDelayCode = 4'd0;
  logic       suspAckN = 1'b1;
  logic       wakeIrq = 1'b0;
  logic       wakeSmi = 1'b0;
  logic       tick = 1'b0;
  logic       suspReqN, clkStopOut, busy;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  typedef struct {
    logic  req;
    logic  stop;
    logic  bsy;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  suspSeqTop dut_i (
    .clk(clk), .rstN(rstN), .haltCmdWr(haltCmdWr), .stopClkCmdWr(stopClkCmdWr),
    .cmdData(cmdData), .fullSuspMode(fullSuspMode), .pllDelayCode(pllDelayCode),
    .suspAckN(suspAckN), .wakeIrq(wakeIrq), .wakeSmi(wakeSmi), .tick(tick),
    .suspReqN(suspReqN), .clkStopOut(clkStopOut), .busy(busy)
  );

  // monitor: compare outputs just after each edge with the queued expectation
  always begin
    @(posedge clk);
    #1;
    if (expQ.size() != 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if ({suspReqN, clkStopOut, busy} !== {e.req, e.stop, e.bsy}) begin
        fails++;
        $display("FAIL %s: req/stop/busy actual %b%b%b expected %b%b%b",
                 e.tag, suspReqN, clkStopOut, busy, e.req, e.stop, e.bsy);
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  // driver: queue expectation for the outputs after the coming edge
  task automatic step(input logic r, input logic s, input logic b, input string tag);
    expItem_t e;
    e.req = r; e.stop = s; e.bsy = b; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic writeCmd(input logic isStop, input logic [7:0] d, input string tag);
    haltCmdWr = !isStop;
    stopClkCmdWr = isStop;
    cmdData = d;
    step(0, 0, 1, tag);
    haltCmdWr = 0;
    stopClkCmdWr = 0;
  endtask

  task automatic pulseWake(input logic useSmi, input logic r, input logic s,
                           input logic b, input string tag);
    wakeIrq = !useSmi;
    wakeSmi = useSmi;
    step(r, s, b, tag);
    wakeIrq = 0;
    wakeSmi = 0;
  endtask

  task automatic ackLow(input logic r, input logic s, input string tag);
    suspAckN = 0;
    step(r, s, 1, tag);
  endtask

  task automatic finishAck(input string tag);
    step(1, 0, 1, tag);
    suspAckN = 1;
    step(1, 0, 0, tag);
  endtask

  // n ticks with a gap cycle after each; release after the last one
  task automatic runTicks(input int n, input string tag);
    for (int i = 1; i <= n; i++) begin
      tick = 1;
      if (i == n) step(1, 0, 1, tag);
      else        step(0, 0, 1, tag);
      tick = 0;
      if (i != n) step(0, 0, 1, tag);
    end
  endtask

  task automatic fullResume(input logic [3:0] code, input int n, input string tag);
    pllDelayCode = code;
    fullSuspMode = 1;
    writeCmd(0, 8'h3C, tag);
    ackLow(0, 1, "R4 stop after ack");
    pulseWake(1, 0, 0, 1, "R5 stop drops on wake");
    runTicks(n, tag);
    finishAck("R7 end full");
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 0, "R1 reset state");
    rstN = 1;
    step(1, 0, 0, "R1 idle after reset");

    // halt only, IRQ wake, data A5
    writeCmd(0, 8'hA5, "R1 halt start");
    step(0, 0, 1, "R2 wait ack");
    step(0, 0, 1, "R2 wait ack");
    haltCmdWr = 1; step(0, 0, 1, "R8 write in req"); haltCmdWr = 0;
    ackLow(0, 0, "R3 halted no stop");
    tick = 1; step(0, 0, 1, "R3 tick no effect"); tick = 0;
    step(0, 0, 1, "R3 halted");
    pulseWake(0, 1, 0, 1, "R3 irq release");
    haltCmdWr = 1; step(1, 0, 1, "R8 write in release"); haltCmdWr = 0;
    finishAck("R7 busy until ack");
    step(1, 0, 0, "R8 no restart");

    // halt only, SMI wake, data 00
    writeCmd(0, 8'h00, "R1 data ignored");
    ackLow(0, 0, "R3 halted");
    pulseWake(1, 1, 0, 1, "R3 smi release");
    finishAck("R7 end");

    // full suspend codes
    fullResume(4'd3, 3, "R5 code3");
    fullResume(4'd0, 1, "R5 code0");
    fullResume(4'd15, 15, "R5 code15");

    // busy write ignored in stopped, mode flips ignored
    pllDelayCode = 4'd2;
    fullSuspMode = 1;
    writeCmd(0, 8'hFF, "R4 start");
    fullSuspMode = 0;
    ackLow(0, 1, "R4 mode sampled at write");
    stopClkCmdWr = 1; step(0, 1, 1, "R8 write in stopped"); stopClkCmdWr = 0;
    pulseWake(0, 0, 0, 1, "R5 wake");
    runTicks(2, "R5 code2");
    finishAck("R7 end");

    // stop-clock command in mode 0
    writeCmd(1, 8'h11, "R6 start");
    ackLow(0, 1, "R6 stop after ack");
    pulseWake(0, 0, 0, 1, "R6 drop stop");
    runTicks(2, "R6 short delay");
    finishAck("R7 end");

    // wake before ack, halt path
    writeCmd(0, 8'h22, "R9 start");
    pulseWake(0, 0, 0, 1, "R9 early wake");
    step(0, 0, 1, "R9 still waiting");
    ackLow(1, 0, "R9 immediate release");
    finishAck("R9 end");

    // wake before ack, stop-clock path
    writeCmd(1, 8'h33, "R9 stop start");
    pulseWake(1, 0, 0, 1, "R9 early wake");
    ackLow(0, 0, "R9 no stop asserted");
    runTicks(2, "R9 delay");
    finishAck("R9 end");

    // idle wake and simultaneous strobes
    pulseWake(0, 1, 0, 0, "R10 idle wake");
    fullSuspMode = 0;
    haltCmdWr = 1; stopClkCmdWr = 1;
    step(0, 0, 1, "R10 both strobes");
    haltCmdWr = 0; stopClkCmdWr = 0;
    ackLow(0, 1, "R10 stop-clock wins");
    pulseWake(0, 0, 0, 1, "R10 wake");
    runTicks(2, "R10 delay");
    finishAck("R10 end");

    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule